// File: doc/BRIEF.md
# Requester Identity Capture and Configuration Decode

This block holds the identity of a PCI Express function and filters the Type 0 configuration accesses that reach it. Each configuration access arrives as a one-cycle request that carries a 16-bit target identity. The block decides whether the addressed function exists, returns a response one cycle later, and on every successful write records the bus and device numbers that the write carried. These numbers can change at run time, so the block records them again on each write instead of only once.

The block also builds the 16-bit identity that goes into every outgoing request. The number of the issuing function is given at the `req_fn` input. Two numbering schemes are supported and the `alt_mode` input selects between them. The classic scheme has an 8-bit bus, a 5-bit device and a 3-bit function. The wide scheme has an 8-bit bus and an 8-bit function, and in it the implemented functions may be sparse. A 256-bit mask, `fn_mask`, lists the implemented functions, and function 0 always counts as present. When the block sits in a downstream port, `dsp_mode` makes it refuse every device number other than 0.

Top module: `rid_unit`

## Requirements
- R1: After reset the captured bus (`cap_bus`) and captured device (`cap_dev`) are zero, and `req_id` is formed from these zero fields.
- R2: A configuration write that completes without Unsupported Request stores target bits [15:8] as the bus. In classic mode it also stores target bits [7:3] as the device. The new values appear on `cap_bus`, `cap_dev` and `req_id` in the cycle after the request.
- R3: Reads, and writes answered with Unsupported Request, leave `cap_bus` and `cap_dev` unchanged.
- R4: When several writes succeed, the most recent one sets the captured values.
- R5: Every cycle with `cfg_valid` high produces exactly one cycle of `resp_valid` in the next cycle. There is no response without a request.
- R6: In classic mode with `dsp_mode` high, an access whose device field (target bits [7:3]) is nonzero is answered with Unsupported Request (`resp_ur`=1). Device 0 is accepted.
- R7: In classic mode the function number is target bits [2:0]. An access to a function whose `fn_mask` bit is 0 gets Unsupported Request. Function 0 is always accepted.
- R8: In wide mode (`alt_mode`=1) the function number is target bits [7:0]. The function is accepted only if its `fn_mask` bit is 1 or the number is 0. `dsp_mode` has no effect in this mode.
- R9: In classic mode `req_id` = {cap_bus, cap_dev, req_fn[2:0]}. In wide mode `req_id` = {cap_bus, req_fn[7:0]}, and a successful wide-mode write stores device 0.
- R10: `resp_fn` gives the decoded function number of the answered access: zero-extended target bits [2:0] in classic mode, target bits [7:0] in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | 1 selects the 8-bit bus / 8-bit function scheme |
| dsp_mode | input | 1 | 1 makes the block refuse device numbers other than 0 in classic mode |
| fn_mask | input | 256 | Implemented-function mask, one bit per function number |
| cfg_valid | input | 1 | A Type 0 configuration access is present this cycle |
| cfg_write | input | 1 | 1 marks the access as a write, 0 as a read |
| cfg_target | input | 16 | Target identity carried by the access |
| req_fn | input | 8 | Function number of the function issuing a request |
| resp_valid | output | 1 | Response to the access of the previous cycle |
| resp_ur | output | 1 | The response is Unsupported Request |
| resp_fn | output | 8 | Decoded function number of the answered access |
| cap_bus | output | 8 | Captured bus number |
| cap_dev | output | 5 | Captured device number |
| req_id | output | 16 | Identity placed in outgoing requests |

## Verification
The assertions watch several rules on every cycle:
- the response always follows its request by exactly one cycle;
- the captured fields stay still unless a successful write came in;
- a successful write leaves exactly the carried bus in place;
- device refusal holds in downstream mode;
- wide-mode function 0 is always accepted.

Other behaviour shows up only in the bench's scenarios, which drive specific mask patterns and access sequences:
- the sparse mask decode, including unimplemented functions;
- which write wins when several succeed;
- the layout of `req_id` in each scheme;
- the switch between schemes while the captured state is kept.

// File: rtl/rid_pkg.sv
package rid_pkg;
    parameter int BUS_W = 8;
    parameter int DEV_W = 5;
    parameter int FN_W  = 3;
    localparam int WFN_W = DEV_W + FN_W;
    localparam int ID_W  = BUS_W + WFN_W;
    localparam int NFN   = 1 << WFN_W;

    typedef struct packed {
        logic             resp_valid;
        logic             resp_ur;
        logic [WFN_W-1:0] resp_fn;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
    } rid_state_t;
endpackage

// File: rtl/rid_decode.sv
module rid_decode
    import rid_pkg::*;
(
    input  logic             alt_mode,
    input  logic             dsp_mode,
    input  logic [NFN-1:0]   fn_mask,
    input  logic [ID_W-1:0]  target,
    output logic             ur,
    output logic [WFN_W-1:0] fn_num,
    output logic [DEV_W-1:0] dev_num
);
    logic [NFN-1:0] impl_fn;

    generate
        for (genvar i = 0; i < NFN; i++) begin : g_impl
            if (i == 0) begin : g_zero
                assign impl_fn[i] = 1'b1;
            end else begin : g_other
                assign impl_fn[i] = fn_mask[i];
            end
        end
    endgenerate

    always_comb begin
        if (alt_mode) begin
            fn_num  = target[WFN_W-1:0];
            dev_num = '0;
            ur      = !impl_fn[fn_num];
        end else begin
            fn_num  = {{DEV_W{1'b0}}, target[FN_W-1:0]};
            dev_num = target[WFN_W-1:FN_W];
            ur      = !impl_fn[fn_num] || (dsp_mode && (dev_num != '0));
        end
    end
endmodule

// File: rtl/rid_core.sv
module rid_core
    import rid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic             cfg_write,
    input  logic             dec_ur,
    input  logic [WFN_W-1:0] dec_fn,
    input  logic [DEV_W-1:0] dec_dev,
    input  logic [BUS_W-1:0] tgt_bus,
    output rid_state_t       st_q
);
    rid_state_t st_d;

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = cfg_valid;
        st_d.resp_ur    = cfg_valid && dec_ur;
        st_d.resp_fn    = cfg_valid ? dec_fn : '0;
        if (cfg_valid && cfg_write && !dec_ur) begin
            st_d.bus = tgt_bus;
            st_d.dev = dec_dev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rid_idgen.sv
module rid_idgen
    import rid_pkg::*;
(
    input  logic             alt_mode,
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [WFN_W-1:0] req_fn,
    output logic [ID_W-1:0]  req_id
);
    always_comb begin
        if (alt_mode) begin
            req_id = {bus, req_fn};
        end else begin
            req_id = {bus, dev, req_fn[FN_W-1:0]};
        end
    end
endmodule

// File: rtl/rid_unit.sv
module rid_unit
    import rid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_mode,
    input  logic              dsp_mode,
    input  logic [NFN-1:0]    fn_mask,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [ID_W-1:0]   cfg_target,
    input  logic [WFN_W-1:0]  req_fn,
    output logic              resp_valid,
    output logic              resp_ur,
    output logic [WFN_W-1:0]  resp_fn,
    output logic [BUS_W-1:0]  cap_bus,
    output logic [DEV_W-1:0]  cap_dev,
    output logic [ID_W-1:0]   req_id
);
    logic             dec_ur;
    logic [WFN_W-1:0] dec_fn;
    logic [DEV_W-1:0] dec_dev;
    rid_state_t       st_q;

    rid_decode u_dec (
        .alt_mode (alt_mode),
        .dsp_mode (dsp_mode),
        .fn_mask  (fn_mask),
        .target   (cfg_target),
        .ur       (dec_ur),
        .fn_num   (dec_fn),
        .dev_num  (dec_dev)
    );

    rid_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_write (cfg_write),
        .dec_ur    (dec_ur),
        .dec_fn    (dec_fn),
        .dec_dev   (dec_dev),
        .tgt_bus   (cfg_target[ID_W-1:WFN_W]),
        .st_q      (st_q)
    );

    rid_idgen u_idg (
        .alt_mode (alt_mode),
        .bus      (st_q.bus),
        .dev      (st_q.dev),
        .req_fn   (req_fn),
        .req_id   (req_id)
    );

    assign resp_valid = st_q.resp_valid;
    assign resp_ur    = st_q.resp_ur;
    assign resp_fn    = st_q.resp_fn;
    assign cap_bus    = st_q.bus;
    assign cap_dev    = st_q.dev;
endmodule

// File: rtl/rid_unit_chk.sv
module rid_unit_chk
    import rid_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              alt_mode,
    input logic              dsp_mode,
    input logic              cfg_valid,
    input logic              cfg_write,
    input logic [ID_W-1:0]   cfg_target,
    input logic              resp_valid,
    input logic              resp_ur,
    input logic [BUS_W-1:0]  cap_bus,
    input logic [DEV_W-1:0]  cap_dev
);
    assert_resp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> resp_valid);

    assert_no_stray_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !resp_valid);

    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && cfg_write) |=> ($stable(cap_bus) && $stable(cap_dev)));

    assert_ur_write_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ur) |-> ($stable(cap_bus) && $stable(cap_dev)));

    assert_capture_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write) |=> (resp_ur || (cap_bus == $past(cfg_target[ID_W-1:WFN_W]))));

    assert_dsp_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !alt_mode && dsp_mode && (cfg_target[WFN_W-1:FN_W] != '0)) |=> resp_ur);

    assert_wide_fn0_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && alt_mode && (cfg_target[WFN_W-1:0] == '0)) |=> !resp_ur);

    assert_wide_dev_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write && alt_mode) |=> (resp_ur || (cap_dev == '0)));
endmodule

bind rid_unit rid_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alt_mode   (alt_mode),
    .dsp_mode   (dsp_mode),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_target (cfg_target),
    .resp_valid (resp_valid),
    .resp_ur    (resp_ur),
    .cap_bus    (cap_bus),
    .cap_dev    (cap_dev)
);

// File: tb/sim_rid_unit.sv
`timescale 1ns/1ps
module sim_rid_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alt_mode = 1'b0;
    logic         dsp_mode = 1'b0;
    logic [255:0] fn_mask = '0;
    logic         cfg_valid = 1'b0;
    logic         cfg_write = 1'b0;
    logic [15:0]  cfg_target = '0;
    logic [7:0]   req_fn = '0;
    logic         resp_valid;
    logic         resp_ur;
    logic [7:0]   resp_fn;
    logic [7:0]   cap_bus;
    logic [4:0]   cap_dev;
    logic [15:0]  req_id;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    logic [7:0] m_bus = '0;
    logic [4:0] m_dev = '0;

    always #5 clk = ~clk;

    rid_unit u0 (
        .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode), .dsp_mode(dsp_mode),
        .fn_mask(fn_mask), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_target(cfg_target), .req_fn(req_fn), .resp_valid(resp_valid),
        .resp_ur(resp_ur), .resp_fn(resp_fn), .cap_bus(cap_bus),
        .cap_dev(cap_dev), .req_id(req_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one access per call, expected response pushed to the scoreboard.
    task automatic access(input logic wr, input logic [15:0] tgt);
        logic [7:0] fn;
        logic       ur;
        if (alt_mode) begin
            fn = tgt[7:0];
            ur = (fn != 0) && !fn_mask[fn];
        end else begin
            fn = {5'd0, tgt[2:0]};
            ur = ((fn != 0) && !fn_mask[fn]) || (dsp_mode && tgt[7:3] != 0);
        end
        exp_q.push_back({ur, fn});
        if (wr && !ur) begin
            m_bus = tgt[15:8];
            m_dev = alt_mode ? 5'd0 : tgt[7:3];
        end
        cfg_valid  = 1'b1;
        cfg_write  = wr;
        cfg_target = tgt;
        @(negedge clk);
        cfg_valid  = 1'b0;
        cfg_write  = 1'b0;
    endtask

    task automatic settle_and_check_cap(input string req);
        @(negedge clk);
        check(req, {24'd0, cap_bus}, {24'd0, m_bus});
        check(req, {27'd0, cap_dev}, {27'd0, m_dev});
    endtask

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R6/R7/R8 resp_ur", {31'd0, resp_ur}, {31'd0, e[8]});
                check("R10 resp_fn", {24'd0, resp_fn}, {24'd0, e[7:0]});
            end
        end
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                check("watchdog expired", 32'd1, 32'd0);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        req_fn = 8'h05;
        #1;
        check("R1 cap_bus reset", {24'd0, cap_bus}, 32'd0);
        check("R1 cap_dev reset", {27'd0, cap_dev}, 32'd0);
        check("R1 req_id reset", {16'd0, req_id}, 32'h0005);
        check("R5 no response idle", {31'd0, resp_valid}, 32'd0);

        // classic functions 1,2,5; wide functions 0x10,0x80,0xFF; bit 0 left clear
        fn_mask = '0;
        fn_mask[1] = 1'b1; fn_mask[2] = 1'b1; fn_mask[5] = 1'b1;
        fn_mask[8'h10] = 1'b1; fn_mask[8'h80] = 1'b1; fn_mask[8'hFF] = 1'b1;

        access(1'b0, {8'h3A, 5'd4, 3'd1});            // R3 read does not capture
        settle_and_check_cap("R3 read no capture");
        access(1'b1, {8'h3A, 5'd4, 3'd1});            // R2 capture
        settle_and_check_cap("R2 write capture");
        req_fn = 8'h02; #1;
        check("R9 classic req_id", {16'd0, req_id}, {16'd0, 8'h3A, 5'd4, 3'd2});
        access(1'b1, {8'h11, 5'd6, 3'd3});            // R7 unimplemented -> UR
        settle_and_check_cap("R3 UR write no capture");
        access(1'b1, {8'h5C, 5'd9, 3'd0});            // R7 fn0 forced; R4 back-to-back
        access(1'b1, {8'h6D, 5'd3, 3'd5});            // R4 latest wins
        settle_and_check_cap("R4 latest write wins");

        dsp_mode = 1'b1;
        access(1'b1, {8'h21, 5'd2, 3'd1});            // R6 refused
        settle_and_check_cap("R6 refused write no capture");
        access(1'b1, {8'h77, 5'd0, 3'd5});            // R6 device 0 accepted
        settle_and_check_cap("R6 device 0 capture");

        alt_mode = 1'b1;
        access(1'b1, 16'h4280);                        // R8 implemented wide fn
        settle_and_check_cap("R9 wide capture dev 0");
        req_fn = 8'hAB; #1;
        check("R9 wide req_id", {16'd0, req_id}, 32'h42AB);
        access(1'b1, 16'h9981);                        // R8 not implemented
        access(1'b1, 16'h5500);                        // R8 fn 0 always present
        access(1'b1, 16'h6610);                        // R8 dsp ignored in wide mode
        access(1'b0, 16'h13FF);                        // R10 wide fn FF read
        settle_and_check_cap("R8 wide sequence capture");

        alt_mode = 1'b0;
        dsp_mode = 1'b0;
        req_fn = 8'h07; #1;
        check("R9 classic req_id after wide", {16'd0, req_id}, {16'd0, m_bus, m_dev, 3'd7});
        access(1'b1, {8'hC3, 5'd31, 3'd2});
        settle_and_check_cap("R2 classic capture dev 31");

        repeat (2) @(negedge clk);
        check("R5 all responses seen", exp_q.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule